// File: doc/BRIEF.md
# Programmable Interval Timer with One-Shot and Periodic Modes

The block is a 32-bit timer peripheral behind a simple word-addressed register bus. It divides the core clock into timer ticks with a 4-bit divisor. On each tick it advances a count register. When the count reaches a programmed period, it emits a one-cycle interrupt pulse and wraps to zero. An enable field selects whether the timer stops after the first match or keeps repeating.

Before counting can start, software releases the low half of the timer from reset in a global control word and selects unchained dual 32-bit operation. To reprogram the timer, software turns the enable field off, loads the period, zeroes the count and then re-enables. The timer output pin can produce a one-tick pulse or a toggling clock on each match, with an optional inversion stage. Chained, watchdog and external-clock settings are kept in storage only.

Top module: `tmr_event_timer`

## Requirements
- R1: The word addresses are: 1 emulation/clock-speed, 4 count, 5 count-high, 6 period, 7 period-high, 8 control, 9 global control, 10 watchdog control. Each of these words reads back what was last written, except that control bit 0 is read-only status and the count also changes by itself. Reserved words (0, 2, 3, 11 to 15) ignore writes and read as 0.
- R2: After the active-low reset, every register reads 0 and irq_o and tout_o are low.
- R3: The tick divisor is the value in emulation word bits 19:16, where 0 acts as 1. While the timer runs, a tick occurs once every divisor core cycles.
- R4: Global control bit 0 releases the low half of the timer. While that bit is 0, the count is held at 0 and the output state is cleared. Counting also requires global control bits 3:2 to be 01; any other value holds the count.
- R5: A tick on which the count equals the period raises irq_o for exactly one cycle, in the following cycle, and sets the count to 0. One interval therefore lasts period+1 ticks.
- R6: Control bits 7:6 select the enable mode: 01 runs once, 10 runs continuously. In run-once mode the field clears itself to 00 after the first match. In continuous mode the timer keeps matching.
- R7: With control bit 3 at 0 (pulse mode), the output is high for one tick after each match. With bit 3 at 1 (clock mode), the output toggles on each match. Control bit 1 inverts tout_o, and control bit 0 reads the output before inversion.
- R8: A write to the count takes effect in the next cycle and overrides a tick in the same cycle. Counting after the reprogramming sequence starts from the newly written count and period.
- R9: Control bits 9, 8 and 5:4, global control bit 1, the count-high, period-high and watchdog words are stored only and do not change the interval or the output.
- R10: Enable mode values 00 and 11 stop counting: the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse per match |
| tout_o | output | 1 | Timer output pin after inversion |

## Verification
A wrong prescaler phase or divisor decode changes the spacing of irq_o pulses. Because the bench compares irq_o against its model in every cycle, the error shows within one interval. A count that is stuck or off by one shifts the first interrupt, and it also shows at once when the count word is read. An enable field that fails to clear after a run-once match shows as an extra interrupt one interval later, and as a nonzero field on the next control read. A wrong output state shows on tout_o and on the status bit in the cycle after the match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_EMU    = 1;
  localparam int unsigned ADDR_CNT    = 4;
  localparam int unsigned ADDR_CNT_HI = 5;
  localparam int unsigned ADDR_PRD    = 6;
  localparam int unsigned ADDR_PRD_HI = 7;
  localparam int unsigned ADDR_CTRL   = 8;
  localparam int unsigned ADDR_GCTRL  = 9;
  localparam int unsigned ADDR_WDOG   = 10;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_CONT = 2'b10,
    EN_RSVD = 2'b11
  } en_mode_e;

  localparam logic [1:0] GMODE_DUAL32 = 2'b01;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  // >= keeps the phase bounded when the divisor shrinks mid-run
  assign tick_o  = active_i && (pre_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (!active_i || tick_o) pre_q <= '0;
    else                         pre_q <= pre_q + DIV_W'(1);
  end

  assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_eff > DIV_W'(1) && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rel_i,
  input  logic          dual_i,
  input  en_mode_e      en_i,
  input  logic          clkm_i,
  input  logic [DW-1:0] prd_i,
  input  logic          cnt_we_i,
  input  logic [DW-1:0] cnt_wdata_i,
  input  logic          tick_i,
  output logic          active_o,
  output logic [DW-1:0] cnt_o,
  output logic          out_o,
  output logic          irq_o,
  output logic          clr_en_o
);
  logic [DW-1:0] cnt_q;
  logic          out_q, irq_q;
  logic          en_act, pend, match_w;

  assign en_act   = (en_i == EN_ONCE) || (en_i == EN_CONT);
  // a pending pulse keeps ticks alive so it can end after one tick
  assign pend     = out_q && !clkm_i;
  assign active_o = rel_i && dual_i && (en_act || pend);
  assign match_w  = tick_i && en_act && (cnt_q == prd_i);
  assign clr_en_o = match_w && (en_i == EN_ONCE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!rel_i)           cnt_q <= '0;
    else if (cnt_we_i)         cnt_q <= cnt_wdata_i;
    else if (match_w)          cnt_q <= '0;
    else if (tick_i && en_act) cnt_q <= cnt_q + DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  out_q <= 1'b0;
    else if (!rel_i)              out_q <= 1'b0;
    else if (match_w)             out_q <= clkm_i ? !out_q : 1'b1;
    else if (tick_i && !clkm_i)   out_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match_w;
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
  assign irq_o = irq_q;

  assert_hold_in_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> (cnt_q == '0) && !out_q);

  assert_irq_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && cnt_q == '0 && prd_i != '0) |=> !irq_q);

  assert_hold_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !en_act && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 4,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIV_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [DW-1:0]    cnt_i,
  input  logic             status_i,
  input  logic             clr_en_i,
  output logic [DIV_W-1:0] div_o,
  output logic [DW-1:0]    prd_o,
  output en_mode_e         en_o,
  output logic             inv_o,
  output logic             clkm_o,
  output logic             rel_o,
  output logic             dual_o,
  output logic             cnt_we_o,
  output logic [DW-1:0]    cnt_wdata_o
);
  logic [DW-1:0] emu_q, cnt_hi_q, prd_q, prd_hi_q, gctrl_q, wdog_q;
  logic [DW-1:1] ctrl_q;
  logic          wr, ctrl_wr;
  int unsigned   a;

  assign a       = int'(addr_i);
  assign wr      = req_i && we_i;
  assign ctrl_wr = wr && (a == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emu_q <= '0; cnt_hi_q <= '0; prd_q <= '0; prd_hi_q <= '0;
      gctrl_q <= '0; wdog_q <= '0;
    end else if (wr) begin
      case (a)
        ADDR_EMU:    emu_q    <= wdata_i;
        ADDR_CNT_HI: cnt_hi_q <= wdata_i;
        ADDR_PRD:    prd_q    <= wdata_i;
        ADDR_PRD_HI: prd_hi_q <= wdata_i;
        ADDR_GCTRL:  gctrl_q  <= wdata_i;
        ADDR_WDOG:   wdog_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // software write wins over the run-once self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (ctrl_wr)  ctrl_q <= wdata_i[DW-1:1];
    else if (clr_en_i) ctrl_q[7:6] <= EN_OFF;
  end

  always_comb begin
    case (a)
      ADDR_EMU:    rdata_o = emu_q;
      ADDR_CNT:    rdata_o = cnt_i;
      ADDR_CNT_HI: rdata_o = cnt_hi_q;
      ADDR_PRD:    rdata_o = prd_q;
      ADDR_PRD_HI: rdata_o = prd_hi_q;
      ADDR_CTRL:   rdata_o = {ctrl_q, status_i};
      ADDR_GCTRL:  rdata_o = gctrl_q;
      ADDR_WDOG:   rdata_o = wdog_q;
      default:     rdata_o = '0;
    endcase
  end

  assign div_o       = emu_q[DIV_LSB +: DIV_W];
  assign prd_o       = prd_q;
  assign en_o        = en_mode_e'(ctrl_q[7:6]);
  assign inv_o       = ctrl_q[1];
  assign clkm_o      = ctrl_q[3];
  assign rel_o       = gctrl_q[0];
  assign dual_o      = (gctrl_q[3:2] == GMODE_DUAL32);
  assign cnt_we_o    = wr && (a == ADDR_CNT);
  assign cnt_wdata_o = wdata_i;

  assert_oneshot_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !ctrl_wr) |=> (en_o == EN_OFF));

  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (a == 0 || a == 2 || a == 3 || a > ADDR_WDOG)) |-> (rdata_o == '0));
endmodule

// File: rtl/tmr_event_timer.sv
module tmr_event_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 4,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIV_LSB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          tout_o
);
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    prd, cnt, cnt_wdata;
  en_mode_e         en;
  logic             inv, clkm, rel, dual, cnt_we;
  logic             tick, active, out, clr_en;

  tmr_regs #(.DW(DW), .AW(AW), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .status_i(out), .clr_en_i(clr_en),
    .div_o(div), .prd_o(prd), .en_o(en), .inv_o(inv), .clkm_o(clkm),
    .rel_o(rel), .dual_o(dual), .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .active_i(active), .div_i(div), .tick_o(tick)
  );

  tmr_core #(.DW(DW)) u_core (
    .clk_i, .rst_ni, .rel_i(rel), .dual_i(dual), .en_i(en), .clkm_i(clkm),
    .prd_i(prd), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata), .tick_i(tick),
    .active_o(active), .cnt_o(cnt), .out_o(out), .irq_o(irq_o), .clr_en_o(clr_en)
  );

  assign tout_o = out ^ inv;

  assert_status_pre_inv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && int'(addr_i) == ADDR_CTRL) |-> (rdata_o[0] == (tout_o ^ inv)));
endmodule

// File: tb/tmr_event_timer_tb_top.sv
module tmr_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, tout;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  tmr_event_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_emu, m_cnt, m_cnthi, m_prd, m_prdhi, m_ctrl, m_g, m_wd;
  int          m_pre;
  logic        m_out, m_irq;

  function automatic logic [31:0] m_read(int a);
    case (a)
      1: return m_emu;   4: return m_cnt;  5: return m_cnthi;
      6: return m_prd;   7: return m_prdhi;
      8: return {m_ctrl[31:1], m_out};
      9: return m_g;     10: return m_wd;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_emu = 0; m_cnt = 0; m_cnthi = 0; m_prd = 0; m_prdhi = 0;
      m_ctrl = 0; m_g = 0; m_wd = 0; m_pre = 0; m_out = 0; m_irq = 0;
    end else begin
      logic [1:0] en;
      logic run_en, clkm, active, tick, match, wr, n_out;
      logic [31:0] n_cnt, n_ctrl;
      int dv, n_pre;
      en     = m_ctrl[7:6];
      run_en = (en == 2'b01) || (en == 2'b10);
      clkm   = m_ctrl[3];
      dv     = int'(m_emu[19:16]); if (dv == 0) dv = 1;
      active = m_g[0] && (m_g[3:2] == 2'b01) && (run_en || (m_out && !clkm));
      tick   = active && (m_pre >= dv - 1);
      match  = tick && run_en && (m_cnt == m_prd);
      wr     = req && we;
      n_pre  = (!active || tick) ? 0 : m_pre + 1;
      n_cnt  = m_cnt;
      if (!m_g[0]) n_cnt = 0;
      else if (wr && addr == 4) n_cnt = wdata;
      else if (match) n_cnt = 0;
      else if (tick && run_en) n_cnt = m_cnt + 1;
      n_out = m_out;
      if (!m_g[0]) n_out = 0;
      else if (match) n_out = clkm ? !m_out : 1'b1;
      else if (tick && !clkm) n_out = 0;
      n_ctrl = m_ctrl;
      if (wr && addr == 8) n_ctrl = wdata;
      else if (match && en == 2'b01) n_ctrl[7:6] = 2'b00;
      if (wr) case (int'(addr))
        1: m_emu = wdata;   5: m_cnthi = wdata; 6: m_prd = wdata;
        7: m_prdhi = wdata; 9: m_g = wdata;     10: m_wd = wdata;
        default: ;
      endcase
      m_pre = n_pre; m_cnt = n_cnt; m_out = n_out; m_ctrl = n_ctrl; m_irq = match;
    end
  end

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", req_tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cyc > 2) begin
      check("R5 irq", {31'b0, irq}, {31'b0, m_irq});
      check("R7 tout", {31'b0, tout}, {31'b0, m_out ^ m_ctrl[1]});
      if (req && !we) check("R1 rdata", rdata, m_read(int'(addr)));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr_reg(int a, logic [31:0] d);
    @(posedge clk); #5;
    req = 1; we = 1; addr = 4'(a); wdata = d;
    @(posedge clk); #5;
    req = 0; we = 0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(posedge clk); #5;
    req = 1; we = 0; addr = 4'(a);
    @(negedge clk); d = rdata;
    @(posedge clk); #5;
    req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns cycle stamp of next irq, or -1 after limit
  task automatic next_irq(int limit, output int stamp);
    stamp = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) begin stamp = cyc; break; end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [31:0] d, d2;
    int t0, t1, nirq;
    idle(3); rst_n = 1; idle(2);

    // R2 reset state
    check("R2 irq", {31'b0, irq}, 32'h0);
    check("R2 tout", {31'b0, tout}, 32'h0);
    rd_reg(8, d); check("R2 ctrl", d, 32'h0);
    rd_reg(4, d); check("R2 count", d, 32'h0);

    // R1 map and reserved words
    wr_reg(10, 32'h1234_5678); rd_reg(10, d); check("R1 wdog", d, 32'h1234_5678);
    wr_reg(2, 32'hFFFF_FFFF);  rd_reg(2, d);  check("R1 reserved", d, 32'h0);
    wr_reg(13, 32'hFFFF_FFFF); rd_reg(13, d); check("R1 reserved high", d, 32'h0);

    // R4 hold while half in reset; count write ignored
    wr_reg(4, 32'd9); rd_reg(4, d); check("R4 held", d, 32'h0);

    // R8 count write immediate with release on, enable off
    wr_reg(9, 32'h5);
    wr_reg(4, 32'd7); rd_reg(4, d); check("R8 count write", d, 32'd7);
    idle(5); rd_reg(4, d); check("R10 off holds", d, 32'd7);

    // R3/R5 continuous, divisor 3, period 4 -> 15 cycles
    wr_reg(1, 32'h0003_0000); wr_reg(6, 32'd4); wr_reg(4, 32'd0);
    wr_reg(8, 32'h80);
    next_irq(100, t0); next_irq(100, t1);
    check("R5 interval div3", t1 - t0, 32'd15);
    // R7 status bit right after match in pulse mode
    rd_reg(8, d); check("R7 status", {31'b0, d[0]}, {31'b0, tout});

    // R9 stored-only bits leave interval unchanged
    wr_reg(8, 32'h3B0); wr_reg(9, 32'h7); wr_reg(7, 32'hFFFF); wr_reg(5, 32'h55);
    next_irq(100, t0); next_irq(100, t1);
    check("R9 interval", t1 - t0, 32'd15);

    // R3 divisor 0 acts as 1
    wr_reg(8, 32'h0); wr_reg(1, 32'h0); wr_reg(6, 32'd2); wr_reg(4, 32'd0);
    wr_reg(8, 32'h80);
    next_irq(50, t0); next_irq(50, t1);
    check("R3 div0", t1 - t0, 32'd3);

    // R7 clock mode with inversion
    wr_reg(8, 32'h8A); idle(20);
    rd_reg(8, d); check("R7 inv", {31'b0, tout}, {31'b0, ~d[0]});

    // R6 run once
    wr_reg(8, 32'h0); wr_reg(6, 32'd5); wr_reg(4, 32'd0); wr_reg(8, 32'h40);
    nirq = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq) nirq++; end
    check("R6 single irq", nirq, 32'd1);
    rd_reg(8, d); check("R6 field cleared", {30'b0, d[7:6]}, 32'h0);

    // R10 mode 11 holds count
    wr_reg(4, 32'd3); wr_reg(8, 32'hC0);
    rd_reg(4, d); idle(6); rd_reg(4, d2); check("R10 mode11", d2, d);

    // R4 gctrl mode 10 holds count
    wr_reg(9, 32'h9); wr_reg(8, 32'h80);
    rd_reg(4, d); idle(6); rd_reg(4, d2); check("R4 mode10 holds", d2, d);

    // R8 restart sequence: count = period with divisor 15 -> match on first tick
    wr_reg(9, 32'h5); wr_reg(8, 32'h0); wr_reg(1, 32'h000F_0000);
    wr_reg(6, 32'd20); wr_reg(4, 32'd20); wr_reg(8, 32'h80);
    next_irq(20, t0);
    check("R8 restart", {31'b0, t0 > 0}, 32'h1);

    // R4 release off clears count
    wr_reg(9, 32'h4); rd_reg(4, d); check("R4 reset clears", d, 32'h0);

    done = 1;
    summary();
  end
endmodule